// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block sets the instruction-cycle rhythm of a small pipelined 8-bit controller core and owns its program counter. The oscillator clock is halved, and each halved period steps a phase counter through four non-overlapping phases. One pass through the four phases is one instruction cycle, eight oscillator cycles long. All phase outputs are one-hot enables in the oscillator clock domain. They are not derived clocks.

The program counter advances at the start of the first phase, and the fetch of the next word happens in that same phase. A jump or call target, or a write to the counter's low byte, is sampled at the close of an instruction cycle. That change costs one extra instruction cycle. During the extra cycle the stall output is high, the fetch strobe is marked invalid and the counter holds its value. At the close of the extra cycle the counter takes the new address. Decode, arithmetic, memories and the return stack sit outside this block.

Top module: `instr_phase_seq`

## Requirements
- R1: Exactly one bit of `t_phase` is high at any time (bit 0 = first phase, bit 3 = last). Each bit stays high for two consecutive oscillator cycles, and the phases repeat in the order bit 0, 1, 2, 3.
- R2: `t1_sync` is high exactly while `t_phase[0]` is high. That is two of every eight oscillator cycles, a 1:3 high-to-low ratio at one eighth of the oscillator rate.
- R3: A synchronous active-high `rst` sampled high makes the next cycle the first oscillator cycle of phase bit 0, with `pc_o` zero and `stall_o` low.
- R4: With no accepted change, `pc_o` increases by one at the edge that enters phase bit 0 and wraps to zero after all ones. It does not change at any other edge.
- R5: `fetch_o` is high only in the first oscillator cycle of phase bit 0. `fetch_valid_o` equals `fetch_o` while `stall_o` is low, and is low otherwise.
- R6: A jump request is sampled only at the edge that ends the last oscillator cycle of phase bit 3 when `stall_o` is low. The following instruction cycle then has `stall_o` high throughout and `pc_o` unchanged. In the cycle after that, `pc_o` equals the sampled target.
- R7: A low-byte write, sampled under the same rule and with the same stall timing, makes `pc_o` equal the counter's value at the sampling edge with bits [7:0] replaced by `pclo_data`.
- R8: When a jump request and a low-byte write are sampled together, the jump target wins.
- R9: Requests present while `stall_o` is high are ignored. The stall lasts exactly one instruction cycle, and the counter then takes the target sampled before the stall.
- R10: Requests present in any oscillator cycle other than the last one of phase bit 3 have no effect on `pc_o` or `stall_o`.
- R11: `pc_lo_o` always equals bits [7:0] of `pc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| jmp_req | input | 1 | Jump or call request |
| jmp_addr | input | PC_W | Jump or call target |
| pclo_wr | input | 1 | Write request for the counter's low byte |
| pclo_data | input | 8 | New low byte |
| t_phase | output | 4 | One-hot phase enables, bit 0 first |
| t1_sync | output | 1 | Sync output, high during phase bit 0 |
| fetch_o | output | 1 | Fetch strobe, first oscillator cycle of each instruction cycle |
| fetch_valid_o | output | 1 | Fetched word is to be used |
| stall_o | output | 1 | Extra branch cycle in progress |
| pc_o | output | PC_W | Program counter |
| pc_lo_o | output | 8 | Low byte of the program counter |

## Verification
The bench builds the block with a 10-bit counter. This keeps two upper bits above the writable low byte, so a low-byte write can be seen to keep them. It also puts the wrap from all ones to zero within reach of a directed jump near the top of the range. Random request pulses land in every oscillator slot, including during stalls. This exercises both the single sampling point and the rule that requests are ignored while a stall is in progress.

// File: rtl/iseq_pkg.sv
package iseq_pkg;
  localparam int NUM_PHASES = 4;
  localparam int MAX_PC_W   = 32;

  typedef enum logic [1:0] {PH_T1, PH_T2, PH_T3, PH_T4} phase_e;

  // sequential successor of a counter value (caller truncates to its width)
  function automatic logic [MAX_PC_W-1:0] pc_step(input logic [MAX_PC_W-1:0] pc);
    return pc + 32'd1;
  endfunction

  // replace the low byte of a counter value, keeping the upper bits
  function automatic logic [MAX_PC_W-1:0] merge_low(input logic [MAX_PC_W-1:0] pc,
                                                    input logic [7:0] lo);
    return {pc[MAX_PC_W-1:8], lo};
  endfunction
endpackage

// File: rtl/iseq_phase_gen.sv
module iseq_phase_gen
  import iseq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  output logic                  half_q,
  output phase_e                phase_q,
  output logic [NUM_PHASES-1:0] phase_oh,
  output logic                  cycle_end
);
  always_ff @(posedge clk) begin
    if (rst) begin
      half_q  <= 1'b0;
      phase_q <= PH_T1;
    end else begin
      half_q <= ~half_q;
      if (half_q) phase_q <= phase_e'(phase_q + 2'd1);
    end
  end

  assign cycle_end = half_q && (phase_q == PH_T4);

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_dec
    assign phase_oh[g] = (phase_q == phase_e'(g));
  end
endmodule

// File: rtl/iseq_pc_ctrl.sv
module iseq_pc_ctrl
  import iseq_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cycle_end,
  input  logic            jmp_req,
  input  logic [PC_W-1:0] jmp_addr,
  input  logic            lo_wr,
  input  logic [7:0]      lo_data,
  output logic [PC_W-1:0] pc,
  output logic            stall,
  output logic            take
);
  logic [PC_W-1:0] tgt_q;
  logic [PC_W-1:0] req_tgt;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] lo_tgt;

  assign seq_pc  = PC_W'(pc_step(MAX_PC_W'(pc)));
  assign lo_tgt  = PC_W'(merge_low(MAX_PC_W'(pc), lo_data));
  assign req_tgt = jmp_req ? jmp_addr : lo_tgt;
  assign take    = cycle_end && !stall && (jmp_req || lo_wr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      stall <= 1'b0;
      tgt_q <= '0;
    end else if (cycle_end) begin
      if (stall) begin
        pc    <= tgt_q;
        stall <= 1'b0;
      end else if (take) begin
        stall <= 1'b1;
        tgt_q <= req_tgt;
      end else begin
        pc <= seq_pc;
      end
    end
  end
endmodule

// File: rtl/instr_phase_seq.sv
module instr_phase_seq
  import iseq_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            jmp_req,
  input  logic [PC_W-1:0] jmp_addr,
  input  logic            pclo_wr,
  input  logic [7:0]      pclo_data,
  output logic [3:0]      t_phase,
  output logic            t1_sync,
  output logic            fetch_o,
  output logic            fetch_valid_o,
  output logic            stall_o,
  output logic [PC_W-1:0] pc_o,
  output logic [7:0]      pc_lo_o
);
  logic   div_half;
  logic   cycle_end;
  logic   take_req;
  phase_e phase_cur;

  iseq_phase_gen u_phase (
    .clk       (clk),
    .rst       (rst),
    .half_q    (div_half),
    .phase_q   (phase_cur),
    .phase_oh  (t_phase),
    .cycle_end (cycle_end)
  );

  iseq_pc_ctrl #(.PC_W(PC_W)) u_pc (
    .clk       (clk),
    .rst       (rst),
    .cycle_end (cycle_end),
    .jmp_req   (jmp_req),
    .jmp_addr  (jmp_addr),
    .lo_wr     (pclo_wr),
    .lo_data   (pclo_data),
    .pc        (pc_o),
    .stall     (stall_o),
    .take      (take_req)
  );

  assign t1_sync       = (phase_cur == PH_T1);
  assign fetch_o       = (phase_cur == PH_T1) && !div_half;
  assign fetch_valid_o = fetch_o && !stall_o;
  assign pc_lo_o       = pc_o[7:0];
endmodule

// File: rtl/iseq_chk.sv
module iseq_chk #(
  parameter int PC_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      t_phase,
  input logic            t1_sync,
  input logic            fetch_o,
  input logic            fetch_valid_o,
  input logic            stall_o,
  input logic [PC_W-1:0] pc_o,
  input logic            div_half,
  input logic            cycle_end,
  input logic            take_req
);
  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(t_phase) == 1); // R1
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !div_half |=> $stable(t_phase)); // R1
  AST_SYNC_T1: assert property (@(posedge clk) disable iff (rst)
    t1_sync == t_phase[0]); // R2
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (t_phase == 4'b0001 && pc_o == '0 && !stall_o)); // R3
  AST_PC_MIDCYCLE: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> $stable(pc_o)); // R4
  AST_PC_INC: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && !stall_o && !take_req) |=> pc_o == PC_W'($past(pc_o) + 1'b1)); // R4
  AST_FETCH_VALID: assert property (@(posedge clk) disable iff (rst)
    fetch_valid_o |-> (fetch_o && !stall_o)); // R5
  AST_TAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
    take_req |=> (stall_o && $stable(pc_o))); // R6
  AST_STALL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (stall_o && !cycle_end) |=> stall_o); // R9
  AST_STALL_END: assert property (@(posedge clk) disable iff (rst)
    (stall_o && cycle_end) |=> !stall_o); // R9
endmodule

bind instr_phase_seq iseq_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/instr_phase_seq_test.sv
module instr_phase_seq_test;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         jmp_req = 1'b0;
  logic [W-1:0] jmp_addr = '0;
  logic         pclo_wr = 1'b0;
  logic [7:0]   pclo_data = '0;
  logic [3:0]   t_phase;
  logic         t1_sync, fetch_o, fetch_valid_o, stall_o;
  logic [W-1:0] pc_o;
  logic [7:0]   pc_lo_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, kept from the requirements
  int           m_i = 0;
  logic [W-1:0] m_pc = '0;
  logic [W-1:0] m_tgt = '0;
  bit           m_stall = 0;
  string        m_tag = "R3";
  string        dtag = "";

  instr_phase_seq #(.PC_W(W)) uut (.*);

  always #5 clk = ~clk;

  function automatic logic [3:0] exp_phase(input int i);
    return 4'b0001 << (i / 2);
  endfunction

  function automatic logic [W-1:0] exp_lo_merge(input logic [W-1:0] p, input logic [7:0] d);
    logic [W-1:0] r;
    r = p;
    r[7:0] = d;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h (slot %0d)", req, act, exp, m_i);
    end
  endtask

  task automatic tick(input bit r, input bit jr, input logic [W-1:0] ja,
                      input bit lw, input logic [7:0] ld);
    string ptag;
    @(negedge clk);
    if (!rst) begin
      ptag = (dtag != "") ? dtag : m_tag;
      chk("R1", 32'(t_phase), 32'(exp_phase(m_i)));
      chk("R2", 32'(t1_sync), 32'(m_i < 2));
      chk("R5", 32'(fetch_o), 32'(m_i == 0));
      chk("R5", 32'(fetch_valid_o), 32'(m_i == 0 && !m_stall));
      chk(ptag, 32'(stall_o), 32'(m_stall));
      chk(ptag, 32'(pc_o), 32'(m_pc));
      chk("R11", 32'(pc_lo_o), 32'(m_pc[7:0]));
    end
    rst = r; jmp_req = jr; jmp_addr = ja; pclo_wr = lw; pclo_data = ld;
    @(posedge clk);
    #1;
    if (r) begin
      m_i = 0; m_pc = '0; m_stall = 0; m_tag = "R3";
    end else begin
      if (m_i == 7) begin
        if (m_stall) begin m_pc = m_tgt; m_stall = 0; m_tag = "R9"; end
        else if (jr) begin m_stall = 1; m_tgt = ja; m_tag = lw ? "R8" : "R6"; end
        else if (lw) begin m_stall = 1; m_tgt = exp_lo_merge(m_pc, ld); m_tag = "R7"; end
        else begin m_pc = m_pc + 1'b1; m_tag = "R4"; end
      end else if (jr || lw) begin
        m_tag = "R10";
      end
      m_i = (m_i + 1) % 8;
    end
  endtask

  // one instruction cycle with requests held throughout
  task automatic icycle(input bit jr, input logic [W-1:0] ja, input bit lw, input logic [7:0] ld);
    for (int k = 0; k < 8; k++) tick(0, jr, ja, lw, ld);
  endtask

  // one instruction cycle with requests everywhere except the sampling slot
  task automatic icycle_off(input logic [W-1:0] ja, input logic [7:0] ld);
    for (int k = 0; k < 8; k++) tick(0, k != 7, ja, k != 7, ld);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 3; k++) tick(1, 0, '0, 0, '0);
    dtag = "R3";
    icycle(0, '0, 0, '0);                 // R3 first cycle after reset
    dtag = "R4";
    icycle(0, '0, 0, '0);
    icycle(0, '0, 0, '0);
    dtag = "R6";                          // jump to near top, then wrap R4
    icycle(1, 10'h3FE, 0, '0);
    icycle(0, '0, 0, '0);
    dtag = "R4";
    for (int k = 0; k < 4; k++) icycle(0, '0, 0, '0);
    dtag = "R6";
    icycle(1, 10'h2F0, 0, '0);
    icycle(0, '0, 0, '0);
    dtag = "R7";                          // upper bits 2'b10 kept
    icycle(0, '0, 1, 8'h12);
    icycle(0, '0, 0, '0);
    icycle(0, '0, 0, '0);
    dtag = "R8";                          // both at once: jump target wins
    icycle(1, 10'h155, 1, 8'hAA);
    icycle(0, '0, 0, '0);
    icycle(0, '0, 0, '0);
    dtag = "R9";                          // request held during the stall
    icycle(1, 10'h0C3, 0, '0);
    icycle(1, 10'h377, 1, 8'h55);
    icycle(0, '0, 0, '0);
    dtag = "R10";
    icycle_off(10'h111, 8'h99);
    icycle_off(10'h222, 8'h66);
    icycle(0, '0, 0, '0);
    dtag = "R3";                          // reset in the middle of a cycle
    tick(0, 0, '0, 0, '0);
    tick(0, 0, '0, 0, '0);
    tick(0, 0, '0, 0, '0);
    tick(1, 0, '0, 0, '0);
    icycle(0, '0, 0, '0);
    dtag = "";
    for (int k = 0; k < 3000; k++)
      tick(0, ($urandom % 23) == 0, W'($urandom), ($urandom % 19) == 0, 8'($urandom));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule